// File: doc/BRIEF.md
# Real-Time Clock Carry and Alarm Flag Register

This block is the status and interrupt-control byte of a real-time clock. It keeps two sticky flags and their two interrupt enables. The carry flag reports a seconds carry. It also reports a 64 Hz prescaler carry that arrives while software is reading the 64 Hz count, which tells software that the value it read may be torn and must be read again. The alarm flag reports that the time counters have reached the programmed alarm time. Only alarm fields whose enable bit is set take part in that comparison.

The time counters and the divider chain sit outside this block. They appear here as carry strobes, a read-in-progress level, a divider-reset pulse, and packed vectors of counter and alarm field values. Software reaches the byte through a simple write strobe and a combinational read port.

The two flags start at 0 in simulation. They cannot be raised until they have been armed: the carry flag by a divider-reset pulse, and the alarm flag by a write of the alarm fields.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: The read byte holds the carry flag at bit 7, the carry interrupt enable at bit 4, the alarm interrupt enable at bit 3 and the alarm flag at bit 0. Bits 6, 5, 2 and 1 always read 0, and writing 1 to them has no effect.
- R2: After reset the byte reads 0x00 and both interrupt outputs are low.
- R3: Once armed, a seconds carry strobe sets the carry flag on the next clock edge.
- R4: Once armed, a 64 Hz carry strobe sets the carry flag only while the 64 Hz read-in-progress input is high. A 64 Hz carry strobe with that input low leaves the flag unchanged.
- R5: Writing 0 to bit 7 clears the carry flag. Writing 1 to bit 7 sets it, once the flag is armed.
- R6: Once armed, the alarm flag sets when every enabled alarm field equals its time counter. A mismatch in a disabled field is ignored. With no field enabled there is never a match. Field i occupies bits [8i+7:8i] of both packed vectors, and field 0 is seconds.
- R7: Writing 0 to bit 0 clears the alarm flag. Writing 1 to bit 0 leaves the alarm flag unchanged.
- R8: The carry interrupt output equals the carry flag ANDed with the carry enable. The alarm interrupt output equals the alarm flag ANDed with the alarm enable.
- R9: The carry flag stays 0 until a divider-reset pulse has been seen. The alarm flag stays 0 until an alarm-field write strobe has been seen.
- R10: When a hardware set event and a software clear of the same flag occur in the same cycle, the flag ends up set.
- R11: The alarm flag is set by the rising edge of the match. After software clears the flag, it stays clear while the match persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current byte value |
| sec_carry | input | 1 | Seconds counter carry pulse |
| hz64_carry | input | 1 | 64 Hz counter carry pulse |
| hz64_rd | input | 1 | High while the 64 Hz counter is being read |
| div_rst | input | 1 | Divider-reset pulse; arms the carry flag |
| alm_wr | input | 1 | Alarm-field write strobe; arms the alarm flag |
| alm_en | input | NF | Per-field alarm enable |
| alm_val | input | NF*FW | Packed alarm field values |
| time_val | input | NF*FW | Packed time counter values |
| irq_carry | output | 1 | Carry interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
A stuck or wrongly updated flag shows on the read byte and on the matching interrupt output one clock edge after the event or write that should have changed it. The bench therefore samples exactly one cycle after each stimulus.

A broken arming latch shows as a flag that rises before any divider-reset pulse or alarm-field write. A lost match-history register shows as an alarm flag that comes back the cycle after software clears it while the match still holds.

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl #(
  parameter int NF = 7,
  parameter int FW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             sec_carry,
  input  logic             hz64_carry,
  input  logic             hz64_rd,
  input  logic             div_rst,
  input  logic             alm_wr,
  input  logic [NF-1:0]    alm_en,
  input  logic [NF*FW-1:0] alm_val,
  input  logic [NF*FW-1:0] time_val,
  output logic             irq_carry,
  output logic             irq_alarm
);
  localparam int B_CF  = 7;
  localparam int B_CIE = 4;
  localparam int B_AIE = 3;
  localparam int B_AF  = 0;

  logic cf, af, cie, aie;
  logic armed_c, armed_a;
  logic match, match_q;
  logic [NF-1:0] fld_ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign fld_ok[i] = !alm_en[i] ||
                       (alm_val[i*FW +: FW] == time_val[i*FW +: FW]);
  end

  assign match = (|alm_en) && (&fld_ok);

  wire cf_evt = armed_c && (sec_carry || (hz64_carry && hz64_rd) ||
                            (wr_en && wdata[B_CF]));
  wire cf_clr = wr_en && !wdata[B_CF];
  wire af_evt = armed_a && match && !match_q;
  wire af_clr = wr_en && !wdata[B_AF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cf      <= 1'b0;
      af      <= 1'b0;
      cie     <= 1'b0;
      aie     <= 1'b0;
      armed_c <= 1'b0;
      armed_a <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (div_rst) armed_c <= 1'b1;
      if (alm_wr)  armed_a <= 1'b1;
      if (cf_evt)      cf <= 1'b1;
      else if (cf_clr) cf <= 1'b0;
      if (af_evt)      af <= 1'b1;
      else if (af_clr) af <= 1'b0;
      if (wr_en) begin
        cie <= wdata[B_CIE];
        aie <= wdata[B_AIE];
      end
    end
  end

  assign rdata     = {cf, 2'b00, cie, aie, 2'b00, af};
  assign irq_carry = cf && cie;
  assign irq_alarm = af && aie;

  AST_CF_SEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed_c && sec_carry |=> cf); // R3
  AST_CF_RD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed_c && hz64_carry && hz64_rd |=> cf); // R4
  AST_CF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wdata[B_CF] && !sec_carry && !(hz64_carry && hz64_rd) |=> !cf); // R5
  AST_AF_HOLD_W1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[B_AF] && af |=> af); // R7
  AST_CF_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_c |-> !cf); // R9
  AST_AF_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_a |-> !af); // R9
  AST_AF_NO_RESET_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    match_q && match && !af |=> !af); // R11
endmodule

// File: tb/tb_rtc_flag_ctrl.sv
module tb_rtc_flag_ctrl;
  localparam int NF = 7;
  localparam int FW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sec_carry = 0, hz64_carry = 0, hz64_rd = 0;
  logic div_rst = 0, alm_wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NF-1:0] alm_en = 0;
  logic [NF*FW-1:0] alm_val = 0, time_val = 0;
  logic irq_carry, irq_alarm;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_flag_ctrl #(.NF(NF), .FW(FW)) dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wdata = d; cyc(); wr_en = 0; wdata = 0;
  endtask

  task automatic pulse_sec();
    sec_carry = 1; cyc(); sec_carry = 0;
  endtask

  task automatic t_reset();
    chk("R2 byte", rdata, 8'h00);
    chk("R2 irq", {irq_carry, irq_alarm}, 8'h00);
  endtask

  task automatic t_unarmed();
    pulse_sec();
    chk("R9 cf before divider reset", rdata, 8'h00);
    wr(8'h80);
    chk("R9 cf write before arm", rdata, 8'h00);
    alm_en = 7'h01; alm_val[7:0] = 8'h05; time_val[7:0] = 8'h05; cyc();
    chk("R9 af before alarm write", rdata, 8'h00);
    time_val[7:0] = 8'h00; cyc();
    div_rst = 1; alm_wr = 1; cyc(); div_rst = 0; alm_wr = 0;
  endtask

  task automatic t_layout();
    wr(8'h18);
    chk("R1 enables", rdata, 8'h18);
    chk("R8 irqs off", {irq_carry, irq_alarm}, 8'h00);
    wr(8'hFF);
    chk("R1 R5 R7 write all ones", rdata, 8'h98);
    chk("R8 carry irq", {irq_carry, irq_alarm}, 8'h02);
    wr(8'h18);
    chk("R5 clear cf", rdata, 8'h18);
  endtask

  task automatic t_carry();
    pulse_sec();
    chk("R3 seconds carry", rdata, 8'h98);
    wr(8'h18);
    hz64_carry = 1; cyc(); hz64_carry = 0;
    chk("R4 64Hz carry no read", rdata, 8'h18);
    hz64_rd = 1; hz64_carry = 1; cyc(); hz64_carry = 0; hz64_rd = 0;
    chk("R4 64Hz carry during read", rdata, 8'h98);
    wr(8'h08);
    chk("R8 carry irq masked", {irq_carry, irq_alarm}, 8'h00);
    wr(8'h18);
  endtask

  task automatic t_alarm();
    alm_en = 7'h01; alm_val = '0; time_val = '1;
    alm_val[7:0] = 8'h05; time_val[7:0] = 8'h05; cyc();
    chk("R6 match on enabled field", rdata, 8'h19);
    chk("R8 alarm irq", {irq_carry, irq_alarm}, 8'h01);
    wr(8'h18); cyc(); cyc();
    chk("R11 no re-set while match holds", rdata, 8'h18);
    time_val[7:0] = 8'h06; cyc();
    time_val[7:0] = 8'h05; cyc();
    chk("R6 re-set on new match", rdata, 8'h19);
    wr(8'h19);
    chk("R7 write one holds af", rdata, 8'h19);
    wr(8'h18);
    alm_en = 7'h03; time_val[15:8] = 8'h00; alm_val[15:8] = 8'h01; cyc();
    time_val[7:0] = 8'h06; cyc(); time_val[7:0] = 8'h05; cyc();
    chk("R6 enabled field mismatch", rdata, 8'h18);
    alm_en = 7'h00; alm_val = '0; time_val = '0; cyc(); cyc();
    chk("R6 no field enabled", rdata, 8'h18);
  endtask

  task automatic t_race();
    sec_carry = 1; wr_en = 1; wdata = 8'h18; cyc();
    sec_carry = 0; wr_en = 0;
    chk("R10 set beats clear", rdata, 8'h98);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    t_reset();
    t_unarmed();
    t_layout();
    t_carry();
    t_alarm();
    t_race();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule